// File: doc/BRIEF.md
# Synchronous Burst Read Controller

This block is the device-side control logic of a 32-bit memory that is read in synchronous bursts. The host pulls chip enable and latch enable low and presents a start address. The controller loads that address into its burst counter. It then counts an initial latency in valid burst-clock edges and drives the first word. After that it steps through sequential words each time the host asserts burst-advance on a data slot. A ready output tells the host when a slot carries no new word, so that the host inserts a wait state. The counter never increments on such a slot.

The burst clock is not used as a clock. The block oversamples it in its own system clock domain, and a configuration bit decides whether its rising or its falling transitions are the valid edges. A second bit decides whether a data slot falls on every valid edge or on every second one. The counter runs over the whole address space and wraps from the top address to zero. Raising chip enable ends a burst at any point. With the signature select held high while idle, the data output returns identification words and the configuration value. The array itself sits outside the block and is read through a one-cycle synchronous read port.

Top module: `sbr_flash_ctrl`

## Requirements
- R1: After reset, `oe` is 0, `rdy` is 1 and `dout` is zero.
- R2: With `ce_n` and `le_n` both low, a valid burst-clock edge loads `addr` into the burst counter. `cfg[4:2]` holds a latency code c, and L = c + 2 (2 to 9). The first word, read at the loaded address, appears on `dout` with `oe` high on the L-th valid edge after the load, and `oe` stays low before that.
- R3: While idle with `ce_n` low, a low-to-high change of `le_n` loads `addr` before any valid edge arrives, provided the burst clock is running. The first word then follows after L valid edges.
- R4: No burst starts while `ce_n` is high. No burst starts on a rising `le_n` when the burst clock has shown no transition for `RUN_TO` system clocks.
- R5: `cfg[0]` = 0 makes the rising transitions of `kclk` the valid edges, and `cfg[0]` = 1 makes the falling ones valid. Edges of the other polarity neither load an address nor count.
- R6: Once data is flowing, a slot with `adv_n` low and `rdy` high moves to the next sequential word. With `adv_n` high, `dout` and the counter hold.
- R7: With `cfg[1]` = 0 every valid edge is a data slot. With `cfg[1]` = 1 only every second valid edge after the first word is a slot.
- R8: When the word just presented has address bits [1:0] = 2'b11, `rdy` goes low. The next slot presents no new word and does not move the counter, even with `adv_n` low. `rdy` returns high on that slot.
- R9: The counter advances from address 19'h7FFFF to address 0.
- R10: With `ce_n` high at a clock edge, `oe` is low after that edge and the controller is idle. A new burst can start afterwards.
- R11: While idle with `ce_n` low and `sig_sel` high, `dout` shows the signature selected by `addr` with `oe` high. Address 0 gives 32'h00000020, address 1 gives `DEV_CODE` (default 32'h00005A17), address 5 gives `cfg` zero-extended, and any other address gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kclk | input | 1 | Burst clock, sampled on `clk` |
| ce_n | input | 1 | Chip enable, active low |
| le_n | input | 1 | Latch enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| sig_sel | input | 1 | Selects signature read while idle |
| addr | input | 19 | Start address / signature address |
| cfg | input | 5 | [0] falling-edge select, [1] half rate, [4:2] latency code |
| mem_addr | output | 19 | Array read address |
| mem_rd | output | 1 | Array read strobe |
| mem_rdata | input | 32 | Array read data, one `clk` after `mem_addr` |
| dout | output | 32 | Data output |
| oe | output | 1 | Output valid / drive enable |
| rdy | output | 1 | High when the next slot carries new data |

## Verification
The bench moves the start address between the two halves of a burst-clock period. This shows whether the load happens on the selected polarity, because a design that latched on the wrong edge would return the other word. It tests the shortest and the longest latency codes, where an off-by-one counter shows the first word one edge early or late. Bursts are started at a group's third word and just below the top address, so that the wait slot and the wrap collide. A design that moved the counter during the wait slot would skip a word, and one that did not wrap would read past the array. Half rate, a stopped burst clock and a mid-burst abort are each driven on their own. A missing skip, a burst started without a clock, or `oe` held high after chip enable rises would each leave a wrong value at the ports.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

   localparam int CFG_W = 5;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LAT  = 2'd1,
      ST_DATA = 2'd2
   } sbr_state_e;

   // bit 0: falling edge valid, bit 1: word every second slot, bits 4:2: latency code
   typedef struct packed {
      logic [2:0] lat_code;
      logic       half_rate;
      logic       fall_edge;
   } sbr_cfg_t;

   function automatic logic [3:0] lat_edges(input logic [2:0] code);
      return {1'b0, code} + 4'd2;
   endfunction

endpackage

// File: rtl/sbr_edge_det.sv
module sbr_edge_det #(
   parameter int RUN_TO = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kclk,
   input  logic fall_sel,
   output logic vedge,
   output logic running
);
   localparam int RW = $clog2(RUN_TO + 1);

   logic          k_q, k_prev_q;
   logic [RW-1:0] idle_cnt_q;
   logic          rise, fall, any_edge;

   assign rise     = k_q & ~k_prev_q;
   assign fall     = ~k_q & k_prev_q;
   assign any_edge = rise | fall;
   assign vedge    = fall_sel ? fall : rise;
   assign running  = any_edge || (idle_cnt_q < RW'(RUN_TO));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k_q        <= 1'b0;
         k_prev_q   <= 1'b0;
         idle_cnt_q <= RW'(RUN_TO);
      end else begin
         k_q      <= kclk;
         k_prev_q <= k_q;
         if (any_edge)
            idle_cnt_q <= '0;
         else if (idle_cnt_q != RW'(RUN_TO))
            idle_cnt_q <= idle_cnt_q + RW'(1);
      end
   end

   // R5
   edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vedge |-> (k_q != k_prev_q));

endmodule

// File: rtl/sbr_id_mux.sv
module sbr_id_mux
   import sbr_pkg::*;
#(
   parameter int          AW       = 19,
   parameter int          DW       = 32,
   parameter logic [31:0] MFR_CODE = 32'h0000_0020,
   parameter logic [31:0] DEV_CODE = 32'h0000_5A17
) (
   input  logic [AW-1:0]    addr,
   input  logic [CFG_W-1:0] cfg,
   output logic [DW-1:0]    id_word
);
   always_comb begin
      unique case (addr)
         AW'(0):  id_word = DW'(MFR_CODE);
         AW'(1):  id_word = DW'(DEV_CODE);
         AW'(5):  id_word = DW'(cfg);
         default: id_word = '0;
      endcase
   end

endmodule

// File: rtl/sbr_burst_fsm.sv
module sbr_burst_fsm
   import sbr_pkg::*;
#(
   parameter int AW    = 19,
   parameter int DW    = 32,
   parameter int GRP_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vedge,
   input  logic             running,
   input  logic             ce_n,
   input  logic             le_n,
   input  logic             adv_n,
   input  logic             sig_sel,
   input  logic [AW-1:0]    addr,
   input  sbr_cfg_t         cfg,
   input  logic [DW-1:0]    id_word,
   output logic [AW-1:0]    mem_addr,
   output logic             mem_rd,
   input  logic [DW-1:0]    mem_rdata,
   output logic [DW-1:0]    dout,
   output logic             oe,
   output logic             rdy
);
   sbr_state_e    st_q;
   logic [AW-1:0] cnt_q, cnt_nxt;
   logic [3:0]    lat_q, lat_need;
   logic          phase_q, le_prev_q;
   logic [DW-1:0] dout_q;
   logic          oe_q, rdy_q;
   logic          load_edge, load_le, slot;
   logic          last_cur, last_nxt;

   assign cnt_nxt  = cnt_q + AW'(1);
   assign lat_need = lat_edges(cfg.lat_code);

   generate
      if (GRP_W == 0) begin : g_no_group
         assign last_cur = 1'b0;
         assign last_nxt = 1'b0;
      end else begin : g_group
         assign last_cur = &cnt_q[GRP_W-1:0];
         assign last_nxt = &cnt_nxt[GRP_W-1:0];
      end
   endgenerate

   assign load_edge = (st_q == ST_IDLE) && !ce_n && !le_n && !sig_sel && vedge;
   assign load_le   = (st_q == ST_IDLE) && !ce_n && le_n && !le_prev_q &&
                      !sig_sel && running;
   assign slot      = (st_q == ST_DATA) && vedge && (!cfg.half_rate || phase_q);

   assign mem_addr = (st_q == ST_DATA) ? cnt_nxt : cnt_q;
   assign mem_rd   = (st_q != ST_IDLE);
   assign dout     = dout_q;
   assign oe       = oe_q;
   assign rdy      = rdy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cnt_q     <= '0;
         lat_q     <= '0;
         phase_q   <= 1'b0;
         le_prev_q <= 1'b1;
         dout_q    <= '0;
         oe_q      <= 1'b0;
         rdy_q     <= 1'b1;
      end else begin
         le_prev_q <= le_n;
         if (ce_n) begin
            st_q  <= ST_IDLE;
            oe_q  <= 1'b0;
            rdy_q <= 1'b1;
         end else begin
            unique case (st_q)
               ST_IDLE: begin
                  if (sig_sel) begin
                     dout_q <= id_word;
                     oe_q   <= 1'b1;
                  end else begin
                     oe_q   <= 1'b0;
                  end
                  if (load_edge || load_le) begin
                     cnt_q <= addr;
                     lat_q <= '0;
                     st_q  <= ST_LAT;
                  end
               end
               ST_LAT: begin
                  if (vedge) begin
                     if (lat_q == lat_need - 4'd1) begin
                        st_q    <= ST_DATA;
                        dout_q  <= mem_rdata;
                        oe_q    <= 1'b1;
                        phase_q <= 1'b0;
                        rdy_q   <= !last_cur;
                     end else begin
                        lat_q <= lat_q + 4'd1;
                     end
                  end
               end
               ST_DATA: begin
                  if (vedge) begin
                     if (cfg.half_rate && !phase_q) begin
                        phase_q <= 1'b1;
                     end else begin
                        phase_q <= 1'b0;
                        if (!rdy_q) begin
                           rdy_q <= 1'b1;
                        end else if (!adv_n) begin
                           cnt_q  <= cnt_nxt;
                           dout_q <= mem_rdata;
                           rdy_q  <= !last_nxt;
                        end
                     end
                  end
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   // R10
   ce_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> !oe_q);

   // R8
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot && !rdy_q) |=> $stable(cnt_q));

   // R6
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot && rdy_q && !adv_n && !ce_n) |=> (cnt_q == $past(cnt_q) + AW'(1)));

   // R6
   adv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_DATA) && !ce_n && adv_n) |=> $stable(dout_q));

   // R2
   lat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LAT) |-> (lat_q < lat_need));

endmodule

// File: rtl/sbr_flash_ctrl.sv
module sbr_flash_ctrl
   import sbr_pkg::*;
#(
   parameter int          AW       = 19,
   parameter int          DW       = 32,
   parameter int          GRP_W    = 2,
   parameter int          RUN_TO   = 64,
   parameter logic [31:0] MFR_CODE = 32'h0000_0020,
   parameter logic [31:0] DEV_CODE = 32'h0000_5A17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kclk,
   input  logic             ce_n,
   input  logic             le_n,
   input  logic             adv_n,
   input  logic             sig_sel,
   input  logic [AW-1:0]    addr,
   input  logic [CFG_W-1:0] cfg,
   output logic [AW-1:0]    mem_addr,
   output logic             mem_rd,
   input  logic [DW-1:0]    mem_rdata,
   output logic [DW-1:0]    dout,
   output logic             oe,
   output logic             rdy
);
   generate
      if (AW < GRP_W + 1 || AW < 3) begin : g_bad_aw
         $error("sbr_flash_ctrl: AW too small for group size");
      end
      if (DW < CFG_W) begin : g_bad_dw
         $error("sbr_flash_ctrl: DW cannot hold the configuration value");
      end
      if (RUN_TO < 8) begin : g_bad_run
         $error("sbr_flash_ctrl: RUN_TO must be at least 8");
      end
   endgenerate

   sbr_cfg_t      cfg_s;
   logic          vedge, running;
   logic [DW-1:0] id_word;

   assign cfg_s = sbr_cfg_t'(cfg);

   sbr_edge_det #(.RUN_TO(RUN_TO)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .kclk     (kclk),
      .fall_sel (cfg_s.fall_edge),
      .vedge    (vedge),
      .running  (running)
   );

   sbr_id_mux #(
      .AW(AW), .DW(DW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
   ) u_id (
      .addr    (addr),
      .cfg     (cfg),
      .id_word (id_word)
   );

   sbr_burst_fsm #(.AW(AW), .DW(DW), .GRP_W(GRP_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .vedge     (vedge),
      .running   (running),
      .ce_n      (ce_n),
      .le_n      (le_n),
      .adv_n     (adv_n),
      .sig_sel   (sig_sel),
      .addr      (addr),
      .cfg       (cfg_s),
      .id_word   (id_word),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_rdata (mem_rdata),
      .dout      (dout),
      .oe        (oe),
      .rdy       (rdy)
   );

endmodule

// File: tb/sbr_flash_ctrl_tb.sv
module sbr_flash_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        kclk = 1'b0;
   logic        ce_n = 1'b1, le_n = 1'b1, adv_n = 1'b1, sig_sel = 1'b0;
   logic [18:0] addr = '0;
   logic [4:0]  cfg = '0;
   logic [18:0] mem_addr;
   logic        mem_rd;
   logic [31:0] mem_rdata = '0;
   logic [31:0] dout;
   logic        oe, rdy;
   int          n_run = 0, n_fail = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   sbr_flash_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .kclk(kclk), .ce_n(ce_n), .le_n(le_n),
      .adv_n(adv_n), .sig_sel(sig_sel), .addr(addr), .cfg(cfg),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
      .dout(dout), .oe(oe), .rdy(rdy)
   );

   function automatic logic [31:0] word_at(input logic [18:0] a);
      return {13'h0ACE, a} ^ 32'h0F0F_0000;
   endfunction

   always_ff @(posedge clk) mem_rdata <= word_at(mem_addr);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic vclk();
      kclk = 1'b1; waitc(4);
      kclk = 1'b0; waitc(4);
   endtask

   task automatic idle_bus();
      ce_n = 1'b1; le_n = 1'b1; adv_n = 1'b1; sig_sel = 1'b0;
      vclk();
   endtask

   task automatic start_edge(input logic [18:0] a, input logic [2:0] code,
                             input bit half, input bit fall, input string tag);
      int lat = int'(code) + 2;
      idle_bus();
      cfg = {code, half, fall};
      ce_n = 1'b0; le_n = 1'b0; addr = a;
      vclk();
      le_n = 1'b1;
      repeat (lat - 1) vclk();
      chk(oe == 1'b0, {tag, " oe before latency"}, 32'(oe), 32'd0);
      vclk();
      chk(oe == 1'b1, {tag, " oe at latency"}, 32'(oe), 32'd1);
      chk(dout == word_at(a), {tag, " first word"}, dout, word_at(a));
   endtask

   task automatic t_reset();
      chk(oe == 1'b0, "R1 oe", 32'(oe), 32'd0);
      chk(rdy == 1'b1, "R1 rdy", 32'(rdy), 32'd1);
      chk(dout == 32'd0, "R1 dout", dout, 32'd0);
   endtask

   task automatic t_sig();
      idle_bus();
      cfg = 5'b10110;
      ce_n = 1'b0; sig_sel = 1'b1;
      addr = 19'd0; waitc(2);
      chk(dout == 32'h20 && oe, "R11 mfr", dout, 32'h20);
      addr = 19'd1; waitc(2);
      chk(dout == 32'h5A17, "R11 dev", dout, 32'h5A17);
      addr = 19'd5; waitc(2);
      chk(dout == 32'h16, "R11 cfg", dout, 32'h16);
      addr = 19'd2; waitc(2);
      chk(dout == 32'h0, "R11 other", dout, 32'h0);
      sig_sel = 1'b0;
   endtask

   task automatic t_latency();
      start_edge(19'h00123, 3'd0, 1'b0, 1'b0, "R2 L2");
      start_edge(19'h05555, 3'd7, 1'b0, 1'b0, "R2 L9");
   endtask

   task automatic t_le_load();
      idle_bus();
      cfg = 5'b00100;  // L = 3
      ce_n = 1'b0; le_n = 1'b0; addr = 19'h00321; waitc(2);
      le_n = 1'b1; waitc(2);
      addr = 19'h00777;
      repeat (2) vclk();
      chk(oe == 1'b0, "R3 before latency", 32'(oe), 32'd0);
      vclk();
      chk(oe == 1'b1 && dout == word_at(19'h00321), "R3 word", dout,
          word_at(19'h00321));
   endtask

   task automatic t_stopped();
      idle_bus();
      cfg = 5'b00000;
      ce_n = 1'b1; le_n = 1'b0; addr = 19'h00040;
      repeat (4) vclk();
      chk(oe == 1'b0, "R4 ce high no start", 32'(oe), 32'd0);
      le_n = 1'b1;
      waitc(100);
      ce_n = 1'b0; le_n = 1'b0; waitc(2);
      le_n = 1'b1; waitc(3);
      repeat (4) vclk();
      chk(oe == 1'b0, "R4 stopped clock no start", 32'(oe), 32'd0);
   endtask

   task automatic t_edge_sel(input bit fall);
      logic [18:0] ea = 19'h01000, eb = 19'h02000;
      logic [31:0] exp = fall ? word_at(eb) : word_at(ea);
      idle_bus();
      cfg = {3'd0, 1'b0, fall};
      ce_n = 1'b0; le_n = 1'b0; addr = ea;
      kclk = 1'b1; waitc(4);
      addr = eb;
      kclk = 1'b0; waitc(4);
      le_n = 1'b1;
      repeat (2) vclk();
      chk(oe == 1'b1 && dout == exp, fall ? "R5 falling" : "R5 rising", dout, exp);
   endtask

   task automatic t_adv();
      start_edge(19'h00100, 3'd0, 1'b0, 1'b0, "R6 start");
      adv_n = 1'b1;
      repeat (2) vclk();
      chk(dout == word_at(19'h00100), "R6 hold", dout, word_at(19'h00100));
      adv_n = 1'b0;
      vclk();
      chk(dout == word_at(19'h00101), "R6 step1", dout, word_at(19'h00101));
      vclk();
      chk(dout == word_at(19'h00102), "R6 step2", dout, word_at(19'h00102));
   endtask

   task automatic t_half();
      start_edge(19'h00020, 3'd1, 1'b1, 1'b0, "R7 start");
      adv_n = 1'b0;
      vclk();
      chk(dout == word_at(19'h00020), "R7 no slot", dout, word_at(19'h00020));
      vclk();
      chk(dout == word_at(19'h00021), "R7 slot", dout, word_at(19'h00021));
   endtask

   task automatic t_group();
      start_edge(19'h00010, 3'd0, 1'b0, 1'b0, "R8 start");
      adv_n = 1'b0;
      repeat (3) vclk();
      chk(dout == word_at(19'h00013) && rdy == 1'b0, "R8 rdy low", 32'(rdy), 32'd0);
      vclk();
      chk(dout == word_at(19'h00013), "R8 wait holds", dout, word_at(19'h00013));
      chk(rdy == 1'b1, "R8 rdy back", 32'(rdy), 32'd1);
      vclk();
      chk(dout == word_at(19'h00014), "R8 after wait", dout, word_at(19'h00014));
      start_edge(19'h00033, 3'd0, 1'b0, 1'b0, "R8 start last");
      chk(rdy == 1'b0, "R8 first word last", 32'(rdy), 32'd0);
   endtask

   task automatic t_wrap();
      start_edge(19'h7FFFE, 3'd0, 1'b0, 1'b0, "R9 start");
      adv_n = 1'b0;
      vclk();
      chk(dout == word_at(19'h7FFFF) && !rdy, "R9 top", dout, word_at(19'h7FFFF));
      vclk();
      vclk();
      chk(dout == word_at(19'h00000), "R9 wrap", dout, word_at(19'h00000));
   endtask

   task automatic t_abort();
      start_edge(19'h00200, 3'd0, 1'b0, 1'b0, "R10 start");
      ce_n = 1'b1;
      waitc(1);
      chk(oe == 1'b0, "R10 abort", 32'(oe), 32'd0);
      start_edge(19'h00300, 3'd0, 1'b0, 1'b0, "R10 restart");
   endtask

   task automatic finish_tb();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      finish_tb();
   end

   initial begin
      waitc(3);
      t_reset();
      rst_n = 1'b1;
      waitc(2);
      t_sig();
      t_latency();
      t_le_load();
      t_stopped();
      t_edge_sel(1'b0);
      t_edge_sel(1'b1);
      t_adv();
      t_half();
      t_group();
      t_wrap();
      t_abort();
      idle_bus();
      finish_tb();
   end

endmodule